// File: doc/BRIEF.md
# Conditional and Masked Select Unit

This execute-stage unit computes the select-style results of an integer core. For every issued operation it takes an opcode and three source values: the first source, the second source, and the present contents of the destination register. That third operand is read before the write happens. From these it forms either a conditional-zero result or a per-bit three-way selection, and hands a result word and a write-enable to the register file write port.

Two datapaths sit side by side. The first makes whole-word decisions that depend on whether the second source is zero: two conditional-zero forms and a full conditional move. The second makes per-bit decisions: a masked move, an inverted masked move, and a merge in which the old destination bits act as the selector. A single register stage after both datapaths sets the timing. Results therefore appear one clock after the operands are presented, and a synchronous active-high reset clears them.

Top module: `csel_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_o` becomes zero and `wr_en_o` becomes 0 after that edge.
- R2: Opcode 0 (zero-if-equal-zero): the result is zero when `src2_i` is zero and is `src1_i` otherwise, with `wr_en_o` = 1.
- R3: Opcode 1 (zero-if-not-zero): the result is zero when `src2_i` is nonzero and is `src1_i` otherwise, with `wr_en_o` = 1.
- R4: Opcode 2 (masked move): each result bit i is `src1_i[i]` where `src2_i[i]` is 1 and `dst_old_i[i]` where it is 0, with `wr_en_o` = 1.
- R5: Opcode 3 (inverted masked move): each result bit i is `dst_old_i[i]` where `src2_i[i]` is 1 and `src1_i[i]` where it is 0, with `wr_en_o` = 1.
- R6: Opcode 4 (merge): each result bit i is `src2_i[i]` where `dst_old_i[i]` is 1 and `src1_i[i]` where it is 0, with `wr_en_o` = 1.
- R7: Opcode 5 (conditional move): the result is `src1_i` when `src2_i` is nonzero and `dst_old_i` when it is zero, with `wr_en_o` = 1.
- R8: Opcodes 6 and 7 give a result of zero with `wr_en_o` = 0, whatever the operands.
- R9: Outputs after a rising edge depend only on the inputs sampled at that edge, so a new operation can be presented every cycle and each result appears exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0 to 5 legal) |
| src1_i | input | XLEN | First source operand |
| src2_i | input | XLEN | Second source operand, condition or mask |
| dst_old_i | input | XLEN | Current destination register value |
| result_o | output | XLEN | Registered result word |
| wr_en_o | output | 1 | Registered write-enable for the result |

## Verification
The only state in the block is the output register. A wrong value there shows at `result_o` or `wr_en_o` on the very next cycle and is overwritten by the following operation, so each fault is visible for exactly one cycle. The bench therefore samples one clock after every operand change. It issues operations back to back, so that a stale or skewed register stage produces a mismatch on a neighbouring operation. Operand patterns place ones and zeros in both halves of the word and at the ends of the word, so that a broken selector at any bit position changes the observed result.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    SEL_ZERO_EQZ = 3'd0,
    SEL_ZERO_NEZ = 3'd1,
    SEL_MASK_MOV = 3'd2,
    SEL_MASK_INV = 3'd3,
    SEL_MERGE    = 3'd4,
    SEL_COND_MOV = 3'd5
  } sel_op_e;

  function automatic logic is_word_op(input logic [OP_W-1:0] op);
    return (op == SEL_ZERO_EQZ) || (op == SEL_ZERO_NEZ) || (op == SEL_COND_MOV);
  endfunction

  function automatic logic is_bit_op(input logic [OP_W-1:0] op);
    return (op == SEL_MASK_MOV) || (op == SEL_MASK_INV) || (op == SEL_MERGE);
  endfunction
endpackage

// File: rtl/csel_word_path.sv
module csel_word_path
  import csel_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] cond_i,
  input  logic [XLEN-1:0] old_i,
  output logic [XLEN-1:0] res_o
);
  logic cond_nz;

  assign cond_nz = |cond_i;

  always_comb begin
    res_o = '0;
    unique case (op_i)
      SEL_ZERO_EQZ: res_o = cond_nz ? a_i : '0;
      SEL_ZERO_NEZ: res_o = cond_nz ? '0 : a_i;
      SEL_COND_MOV: res_o = cond_nz ? a_i : old_i;
      default:      res_o = '0;
    endcase
  end
endmodule

// File: rtl/csel_bit_path.sv
module csel_bit_path
  import csel_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic [XLEN-1:0] old_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] mov_w;
  logic [XLEN-1:0] inv_w;
  logic [XLEN-1:0] mrg_w;

  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    assign mov_w[b] = mask_i[b] ? a_i[b]    : old_i[b];
    assign inv_w[b] = mask_i[b] ? old_i[b]  : a_i[b];
    assign mrg_w[b] = old_i[b]  ? mask_i[b] : a_i[b];
  end

  always_comb begin
    res_o = '0;
    unique case (op_i)
      SEL_MASK_MOV: res_o = mov_w;
      SEL_MASK_INV: res_o = inv_w;
      SEL_MERGE:    res_o = mrg_w;
      default:      res_o = '0;
    endcase
  end
endmodule

// File: rtl/csel_out_reg.sv
module csel_out_reg #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] d_i,
  input  logic            we_i,
  output logic [XLEN-1:0] q_o,
  output logic            we_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o  <= '0;
      we_o <= 1'b0;
    end else begin
      q_o  <= d_i;
      we_o <= we_i;
    end
  end
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  input  logic [XLEN-1:0] dst_old_i,
  output logic [XLEN-1:0] result_o,
  output logic            wr_en_o
);
  logic [XLEN-1:0] word_res;
  logic [XLEN-1:0] bit_res;
  logic [XLEN-1:0] next_res;
  logic            word_sel;
  logic            bit_sel;
  logic            next_we;

  csel_word_path #(.XLEN(XLEN)) u_word (
    .op_i   (op_i),
    .a_i    (src1_i),
    .cond_i (src2_i),
    .old_i  (dst_old_i),
    .res_o  (word_res)
  );

  csel_bit_path #(.XLEN(XLEN)) u_bit (
    .op_i   (op_i),
    .a_i    (src1_i),
    .mask_i (src2_i),
    .old_i  (dst_old_i),
    .res_o  (bit_res)
  );

  assign word_sel = is_word_op(op_i);
  assign bit_sel  = is_bit_op(op_i);
  assign next_we  = word_sel | bit_sel;
  assign next_res = ({XLEN{word_sel}} & word_res) | ({XLEN{bit_sel}} & bit_res);

  csel_out_reg #(.XLEN(XLEN)) u_oreg (
    .clk  (clk),
    .rst  (rst),
    .d_i  (next_res),
    .we_i (next_we),
    .q_o  (result_o),
    .we_o (wr_en_o)
  );
endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] src1_i,
  input logic [XLEN-1:0] src2_i,
  input logic [XLEN-1:0] dst_old_i,
  input logic [XLEN-1:0] result_o,
  input logic            wr_en_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r2_zero_eqz: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == 3'd0) |->
      (wr_en_o && result_o == (($past(src2_i) == '0) ? '0 : $past(src1_i))));

  a_r3_zero_nez: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == 3'd1) |->
      (wr_en_o && result_o == (($past(src2_i) != '0) ? '0 : $past(src1_i))));

  a_r4_mask_mov: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == 3'd2) |->
      (wr_en_o && result_o == (($past(src1_i) & $past(src2_i)) |
                               ($past(dst_old_i) & ~$past(src2_i)))));

  a_r5_mask_inv: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == 3'd3) |->
      (wr_en_o && result_o == (($past(dst_old_i) & $past(src2_i)) |
                               ($past(src1_i) & ~$past(src2_i)))));

  a_r6_merge: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == 3'd4) |->
      (wr_en_o && result_o == (($past(src2_i) & $past(dst_old_i)) |
                               ($past(src1_i) & ~$past(dst_old_i)))));

  a_r7_cond_mov: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == 3'd5) |->
      (wr_en_o && result_o == (($past(src2_i) != '0) ? $past(src1_i) : $past(dst_old_i))));

  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) > 3'd5) |-> (!wr_en_o && result_o == '0));
endmodule

bind csel_unit csel_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_i      (op_i),
  .src1_i    (src1_i),
  .src2_i    (src2_i),
  .dst_old_i (dst_old_i),
  .result_o  (result_o),
  .wr_en_o   (wr_en_o)
);

// File: tb/csel_unit_tb_top.sv
module csel_unit_tb_top;
  localparam int unsigned XLEN = 64;
  localparam time HALF = 4ns;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2:0]      op_i = '0;
  logic [XLEN-1:0] src1_i = '0;
  logic [XLEN-1:0] src2_i = '0;
  logic [XLEN-1:0] dst_old_i = '0;
  logic [XLEN-1:0] result_o;
  logic            wr_en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #HALF clk = ~clk;

  csel_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .src1_i(src1_i), .src2_i(src2_i),
    .dst_old_i(dst_old_i), .result_o(result_o), .wr_en_o(wr_en_o)
  );

  function automatic logic [XLEN:0] model(input logic [2:0] op, input logic [XLEN-1:0] a,
                                          input logic [XLEN-1:0] c, input logic [XLEN-1:0] d);
    logic [XLEN-1:0] r;
    r = '0;
    for (int i = 0; i < XLEN; i++) begin
      case (op)
        3'd0: r[i] = (c == '0) ? 1'b0 : a[i];
        3'd1: r[i] = (c != '0) ? 1'b0 : a[i];
        3'd2: r[i] = c[i] ? a[i] : d[i];
        3'd3: r[i] = c[i] ? d[i] : a[i];
        3'd4: r[i] = d[i] ? c[i] : a[i];
        3'd5: r[i] = (c != '0) ? a[i] : d[i];
        default: r[i] = 1'b0;
      endcase
    end
    return {(op <= 3'd5), r};
  endfunction

  task automatic check(input string req, input logic [XLEN:0] got, input logic [XLEN:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got we=%0b res=%h, expected we=%0b res=%h",
               req, got[XLEN], got[XLEN-1:0], exp[XLEN], exp[XLEN-1:0]);
    end
  endtask

  task automatic issue(input string req, input logic [2:0] op, input logic [XLEN-1:0] a,
                       input logic [XLEN-1:0] c, input logic [XLEN-1:0] d);
    @(negedge clk);
    op_i = op; src1_i = a; src2_i = c; dst_old_i = d;
    @(posedge clk); #1;
    check(req, {wr_en_o, result_o}, model(op, a, c, d));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    op_i = 3'd5; src1_i = '1; src2_i = '1; dst_old_i = '1;
    @(posedge clk); #1;
    check("R1", {wr_en_o, result_o}, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_zero_forms();
    issue("R2", 3'd0, 64'hDEAD_BEEF_0123_4567, 64'h0, 64'h5555);
    issue("R2", 3'd0, 64'hDEAD_BEEF_0123_4567, 64'h8000_0000_0000_0000, 64'h5555);
    issue("R3", 3'd1, 64'hCAFE_F00D_89AB_CDEF, 64'h0, 64'h1);
    issue("R3", 3'd1, 64'hCAFE_F00D_89AB_CDEF, 64'h1, 64'h1);
  endtask

  task automatic t_masked();
    issue("R4", 3'd2, 64'hFFFF_FFFF_0000_0000, 64'h00FF_00FF_00FF_00FF, 64'h1234_5678_9ABC_DEF0);
    issue("R4", 3'd2, 64'hA5A5_A5A5_A5A5_A5A5, 64'h8000_0000_0000_0001, 64'h0);
    issue("R5", 3'd3, 64'hFFFF_FFFF_0000_0000, 64'h00FF_00FF_00FF_00FF, 64'h1234_5678_9ABC_DEF0);
    issue("R5", 3'd3, 64'h0F0F_0F0F_F0F0_F0F0, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R6", 3'd4, 64'h1111_2222_3333_4444, 64'hEEEE_DDDD_CCCC_BBBB, 64'hFF00_FF00_0F0F_F0F0);
    issue("R6", 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_cmov();
    issue("R7", 3'd5, 64'h0BAD_C0DE_0000_0001, 64'h4000_0000, 64'h7777_7777_7777_7777);
    issue("R7", 3'd5, 64'h0BAD_C0DE_0000_0001, 64'h0, 64'h7777_7777_7777_7777);
  endtask

  task automatic t_illegal();
    issue("R8", 3'd6, '1, '1, '1);
    issue("R8", 3'd7, 64'h1234, 64'h0, 64'h5678);
  endtask

  task automatic t_stream();
    for (int k = 0; k < 8; k++) begin
      issue("R9", 3'(k), {32'h9E37_79B9 * 32'(k + 1), 32'h7F4A_7C15 ^ 32'(k)},
            (k % 2 == 0) ? 64'h0 : 64'h00F0_0F00_F00F_0FF0, 64'hC3C3_3C3C_A55A_5AA5);
    end
  endtask

  task automatic t_reset_mid();
    issue("R9", 3'd2, '1, '1, '0);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1", {wr_en_o, result_o}, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_zero_forms();
    t_masked();
    t_cmov();
    t_illegal();
    t_stream();
    t_reset_mid();
    issue("R7", 3'd5, 64'h1, 64'h2, 64'h3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule